// File: doc/BRIEF.md
# Memory-Mapped 32-Pin GPIO Bank

This block drives and samples 32 general purpose pins from a single-word register bus. Software sets each pin's direction, sets the levels the output pins drive, and reads the levels on the input pins. The output levels live in one data register. That register can be written whole, or changed bit by bit through two alias offsets. One alias forces written ones high and the other forces written ones low, so no read-modify-write is needed. Pin levels pass through a two-flop synchronizer and are captured into a read-only input register on a sampling tick. A control register sets the tick rate to every cycle or every 2, 4 or 8 cycles. The same register can stop capture altogether.

Capture is governed by a two-state machine. In `ST_RUNNING`, a free-running three-bit counter produces the sampling tick, and each tick loads the synchronized pins into the input register. In `ST_HALTED`, the counter is cleared and the input register keeps its last value. The machine takes the `halt` transition (RUNNING to HALTED) when control bit 0 is 1. It takes the `resume` transition (HALTED to RUNNING) when that bit returns to 0. Reset enters `ST_RUNNING`.

The bus accepts one access per clock. A write lands on the rising edge. Read data is combinational from the address while `bus_rd` is high, and is zero otherwise. Addresses are byte offsets, and only the exact word-aligned offsets listed below are decoded.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register reads 0xFFFFFFFF, so every `pin_oe` bit is 0. The output data register, control register and system configuration register read 0, and `pin_out` is 0.
- R2: The direction register at offset 0x034 is read/write. A 0 in bit n makes pin n an output, and `pin_oe[n]` is the inverse of direction bit n from the cycle after the write.
- R3: Writing offset 0x094 sets to 1 every output data bit whose written bit is 1. Bits written as 0 keep their value.
- R4: Writing offset 0x090 clears to 0 every output data bit whose written bit is 1. Bits written as 0 keep their value.
- R5: Offset 0x03C reads and writes the output data register directly. Reads of offsets 0x090 and 0x094 also return the output data register, and `pin_out` equals it.
- R6: Set and clear writes to the same bit in consecutive cycles leave that bit at the value given by the later write.
- R7: The input data register at offset 0x038 is read-only, and writes to it have no effect. With ratio 0 and capture running, the value read after a clock edge equals the pin levels present at the edge two cycles earlier.
- R8: Control bits 2:1 at offset 0x030 select the capture interval. The values 0, 1, 2 and 3 capture every 1, 2, 4 and 8 cycles respectively.
- R9: While control bit 0 is 1, the input data register holds its value whatever the pins do. Once the bit is 0 again, capture resumes.
- R10: The system configuration register at offset 0x010 stores only bit 2, and all its other bits read 0. The control register stores bits 2:0, and bits 31:3 read 0.
- R11: A read of any other offset, including an unaligned one, returns 0, and a write to such an offset changes no register. `bus_rdata` is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Pin levels |
| pin_out | output | 32 | Output levels |
| pin_oe | output | 32 | Per-pin output enable, active high |

## Verification
Some properties are checked by assertions on every cycle: a write to an alias offset takes effect in the next cycle, a direction write reaches `pin_oe` in the next cycle, the input register stays frozen while the machine is halted, unmapped reads return zero, and at ratio 0 the input register follows the synchronizer. Other behaviour shows only in the bench's scenarios: the exact spacing between captures for each ratio value, the two-cycle latency from pin to register, which of two back-to-back alias writes wins, and capture resuming after a halt.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int GPIO_DW    = 32;
    localparam int GPIO_AW    = 12;
    localparam int CTRL_W     = 3;
    localparam int DIV_CNT_W  = 3;

    localparam logic [GPIO_AW-1:0] OFF_SYSCFG = 12'h010;
    localparam logic [GPIO_AW-1:0] OFF_CTRL   = 12'h030;
    localparam logic [GPIO_AW-1:0] OFF_DIR    = 12'h034;
    localparam logic [GPIO_AW-1:0] OFF_DIN    = 12'h038;
    localparam logic [GPIO_AW-1:0] OFF_DOUT   = 12'h03C;
    localparam logic [GPIO_AW-1:0] OFF_CLR    = 12'h090;
    localparam logic [GPIO_AW-1:0] OFF_SET    = 12'h094;

    localparam int SYSCFG_WAKE_BIT = 2;

    typedef enum logic [0:0] {
        ST_RUNNING = 1'b0,
        ST_HALTED  = 1'b1
    } samp_state_t;
endpackage

// File: rtl/gpio_sampler.sv
module gpio_sampler
    import gpio_pkg::*;
#(
    parameter int DW          = GPIO_DW,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    input  logic [1:0]    ratio,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] din_q
);
    localparam int LAST = SYNC_STAGES - 1;

    samp_state_t state_q, state_d;
    logic [DW-1:0]        sync_q [SYNC_STAGES];
    logic [DIV_CNT_W-1:0] cnt_q;
    logic [DIV_CNT_W-1:0] mask;
    logic                 tick;
    logic                 cap_en;
    logic                 cnt_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= pin_in;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUNNING: if (halt)  state_d = ST_HALTED;
            ST_HALTED:  if (!halt) state_d = ST_RUNNING;
            default:               state_d = ST_RUNNING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUNNING;
        else        state_q <= state_d;
    end

    always_comb begin
        mask = DIV_CNT_W'((1 << ratio) - 1);
        tick = ((cnt_q & mask) == mask);
        cap_en  = 1'b0;
        cnt_clr = 1'b0;
        unique case (state_q)
            ST_RUNNING: cap_en  = tick;
            ST_HALTED:  cnt_clr = 1'b1;
            default:    cnt_clr = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_clr) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      din_q <= '0;
        else if (cap_en) din_q <= sync_q[LAST];
    end

    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALTED) |=> $stable(din_q));

    p_ratio0_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUNNING && ratio == 2'd0) |=> (din_q == $past(sync_q[LAST])));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int DW = GPIO_DW,
    parameter int AW = GPIO_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dir_q,
    output logic [DW-1:0]     dout_q,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic wake_q;
    logic hit_syscfg, hit_ctrl, hit_dir, hit_din, hit_dout, hit_clr, hit_set;
    logic [DW-1:0] rd_mux;

    assign hit_syscfg = (bus_addr == AW'(OFF_SYSCFG));
    assign hit_ctrl   = (bus_addr == AW'(OFF_CTRL));
    assign hit_dir    = (bus_addr == AW'(OFF_DIR));
    assign hit_din    = (bus_addr == AW'(OFF_DIN));
    assign hit_dout   = (bus_addr == AW'(OFF_DOUT));
    assign hit_clr    = (bus_addr == AW'(OFF_CLR));
    assign hit_set    = (bus_addr == AW'(OFF_SET));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            dout_q <= '0;
            ctrl_q <= '0;
            wake_q <= 1'b0;
        end else if (bus_wr) begin
            if (hit_dir)    dir_q  <= bus_wdata;
            if (hit_dout)   dout_q <= bus_wdata;
            if (hit_set)    dout_q <= dout_q | bus_wdata;
            if (hit_clr)    dout_q <= dout_q & ~bus_wdata;
            if (hit_ctrl)   ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (hit_syscfg) wake_q <= bus_wdata[SYSCFG_WAKE_BIT];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_syscfg)                   rd_mux[SYSCFG_WAKE_BIT] = wake_q;
        if (hit_ctrl)                     rd_mux[CTRL_W-1:0] = ctrl_q;
        if (hit_dir)                      rd_mux = dir_q;
        if (hit_din)                      rd_mux = din;
        if (hit_dout || hit_clr || hit_set) rd_mux = dout_q;
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_set) |=> ((dout_q & $past(bus_wdata)) == $past(bus_wdata)));

    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_clr) |=> ((dout_q & $past(bus_wdata)) == '0));

    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !(hit_syscfg || hit_ctrl || hit_dir || hit_din ||
                     hit_dout || hit_clr || hit_set)) |-> (bus_rdata == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int DW = GPIO_DW,
    parameter int AW = GPIO_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_oe
);
    logic [DW-1:0]     dir_q;
    logic [DW-1:0]     dout_q;
    logic [DW-1:0]     din_q;
    logic [CTRL_W-1:0] ctrl_q;

    gpio_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .din       (din_q),
        .dir_q     (dir_q),
        .dout_q    (dout_q),
        .ctrl_q    (ctrl_q)
    );

    gpio_sampler #(.DW(DW), .SYNC_STAGES(2)) u_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .halt   (ctrl_q[0]),
        .ratio  (ctrl_q[2:1]),
        .pin_in (pin_in),
        .din_q  (din_q)
    );

    assign pin_out = dout_q;
    assign pin_oe  = ~dir_q;

    p_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFF_DIR)) |=> (pin_oe == ~$past(bus_wdata)));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    logic [31:0] model;
    logic [31:0] rv;

    always #5 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ramp(input int r);
        logic [31:0] prev, cur;
        int last, changes;
        bit gaps_ok, val_ok;
        wr(12'h030, 32'(r << 1));
        bus_addr = 12'h038; bus_rd = 1'b1;
        prev = bus_rdata; last = -1; changes = 0; gaps_ok = 1; val_ok = 1;
        for (int c = 0; c < 96; c++) begin
            @(negedge clk);
            cur = bus_rdata;
            if (r == 0 && c >= 4 && cur != pin_in - 32'd2) val_ok = 0;
            if (c >= 16 && cur != prev) begin
                if (last >= 0 && (c - last) != (1 << r)) gaps_ok = 0;
                last = c; changes++;
            end
            prev = cur;
            pin_in = pin_in + 32'd1;
        end
        bus_rd = 1'b0;
        if (r == 0) check(val_ok, "R7 data-in lags pins by two edges", cur, pin_in - 32'd3);
        check(gaps_ok && changes >= 80 / (1 << r) - 1, "R8 capture interval",
              32'(changes), 32'(80 / (1 << r)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(pin_oe == 32'h0, "R1 pin_oe", pin_oe, 32'h0);
        check(pin_out == 32'h0, "R1 pin_out", pin_out, 32'h0);
        rd(12'h034, rv); check(rv == 32'hFFFF_FFFF, "R1 dir", rv, 32'hFFFF_FFFF);
        rd(12'h030, rv); check(rv == 32'h0, "R1 ctrl", rv, 32'h0);
        rd(12'h010, rv); check(rv == 32'h0, "R1 syscfg", rv, 32'h0);
        bus_addr = 12'h034; #1;
        check(bus_rdata == 32'h0, "R11 rdata idle", bus_rdata, 32'h0);

        // R2 walking direction sweep
        begin
            bit ok = 1; logic [31:0] bad = '0;
            for (int i = 0; i < 32; i++) begin
                wr(12'h034, ~(32'h1 << i));
                if (pin_oe != (32'h1 << i)) begin ok = 0; bad = pin_oe; end
                rd(12'h034, rv);
                if (rv != ~(32'h1 << i)) begin ok = 0; bad = rv; end
            end
            check(ok, "R2 direction sweep", bad, 32'h0);
        end

        // R5 direct output data and alias readback
        wr(12'h03C, 32'hA5A5_0F0F); model = 32'hA5A5_0F0F;
        check(pin_out == model, "R5 pin_out", pin_out, model);
        rd(12'h03C, rv); check(rv == model, "R5 read 0x03C", rv, model);
        rd(12'h090, rv); check(rv == model, "R5 read 0x090", rv, model);
        rd(12'h094, rv); check(rv == model, "R5 read 0x094", rv, model);

        // R3 walking set sweep
        begin
            bit ok = 1; logic [31:0] bad = '0;
            wr(12'h03C, 32'h0); model = 32'h0;
            for (int i = 0; i < 32; i++) begin
                wr(12'h094, 32'h1 << i); model = model | (32'h1 << i);
                if (pin_out != model) begin ok = 0; bad = pin_out; end
            end
            check(ok, "R3 set sweep", bad, model);
            wr(12'h03C, 32'h1234_0000); wr(12'h094, 32'h0000_5678);
            check(pin_out == 32'h1234_5678, "R3 set keeps zeros", pin_out, 32'h1234_5678);
        end

        // R4 walking clear sweep
        begin
            bit ok = 1; logic [31:0] bad = '0;
            wr(12'h03C, 32'hFFFF_FFFF); model = 32'hFFFF_FFFF;
            for (int i = 0; i < 32; i += 2) begin
                wr(12'h090, 32'h1 << i); model = model & ~(32'h1 << i);
                if (pin_out != model) begin ok = 0; bad = pin_out; end
            end
            check(ok, "R4 clear sweep", bad, model);
            check(pin_out == 32'hAAAA_AAAA, "R4 clear pattern", pin_out, 32'hAAAA_AAAA);
        end

        // R6 back-to-back set and clear
        wr(12'h03C, 32'h0);
        wr(12'h094, 32'h0000_0001); wr(12'h090, 32'h0000_0001);
        check(pin_out == 32'h0, "R6 set then clear", pin_out, 32'h0);
        wr(12'h090, 32'h0000_0080); wr(12'h094, 32'h0000_0080);
        check(pin_out == 32'h80, "R6 clear then set", pin_out, 32'h80);

        // R7/R8 capture timing for every ratio
        pin_in = 32'h100;
        for (int r = 0; r < 4; r++) ramp(r);
        wr(12'h030, 32'h0);

        // R7 data-in read-only
        pin_in = 32'hCAFE_F00D; repeat (6) @(negedge clk);
        wr(12'h038, 32'h0); rd(12'h038, rv);
        check(rv == 32'hCAFE_F00D, "R7 write ignored", rv, 32'hCAFE_F00D);

        // R9 halt and resume
        wr(12'h030, 32'h1); repeat (3) @(negedge clk);
        pin_in = 32'h0BAD_BEEF; repeat (20) @(negedge clk);
        rd(12'h038, rv);
        check(rv == 32'hCAFE_F00D, "R9 halted holds", rv, 32'hCAFE_F00D);
        wr(12'h030, 32'h0); repeat (6) @(negedge clk);
        rd(12'h038, rv);
        check(rv == 32'h0BAD_BEEF, "R9 resume", rv, 32'h0BAD_BEEF);

        // R10 register widths
        wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, rv);
        check(rv == 32'h4, "R10 syscfg bit 2", rv, 32'h4);
        wr(12'h010, 32'h0); rd(12'h010, rv);
        check(rv == 32'h0, "R10 syscfg clear", rv, 32'h0);
        wr(12'h030, 32'hFFFF_FFF8); rd(12'h030, rv);
        check(rv == 32'h0, "R10 ctrl upper bits", rv, 32'h0);
        wr(12'h030, 32'h6); rd(12'h030, rv);
        check(rv == 32'h6, "R10 ctrl ratio field", rv, 32'h6);
        wr(12'h030, 32'h0);

        // R11 unmapped offsets
        wr(12'h03C, 32'h1357_9BDF); wr(12'h034, 32'h0F0F_0F0F);
        wr(12'h000, 32'hFFFF_FFFF); wr(12'h044, 32'hFFFF_FFFF); wr(12'h035, 32'hFFFF_FFFF);
        rd(12'h000, rv); check(rv == 32'h0, "R11 read 0x000", rv, 32'h0);
        rd(12'h044, rv); check(rv == 32'h0, "R11 read 0x044", rv, 32'h0);
        rd(12'h035, rv); check(rv == 32'h0, "R11 read unaligned", rv, 32'h0);
        check(pin_out == 32'h1357_9BDF, "R11 dout untouched", pin_out, 32'h1357_9BDF);
        check(pin_oe == 32'hF0F0_F0F0, "R11 dir untouched", pin_oe, 32'hF0F0_F0F0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule